// File: doc/BRIEF.md
# Page-Program Staging Buffer

This block holds one 128-byte page of data and sends it to a serial NOR flash as a single page-program transfer. A single storage array serves either as the read prefetch store or as the program staging store, and one configuration bit chooses between the two. The role change takes effect a few clock cycles after the write, because the store may still be busy. Reading the bit back returns the role that is actually in force, so software polls the bit until it shows the value it wrote.

In program mode, software pushes 32 little-endian words through one data port. It loads the target address into four byte registers and then writes the program command code. The block lowers chip select and clocks out the page-program opcode, the address with its most significant byte first, and all 128 bytes in fill order. It then raises chip select and clears the busy bit of the command register. The serial side is SPI mode 0: the clock idles low, each bit is sampled on the rising edge, and each byte goes out MSB first.

Top module: `pp_stage_buf`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sck is 0 and spi_mosi is 0. The role bit (offset 0x08, bit 0) reads 0 and the busy bit (offset 0x00, bit 4) reads 0.
- R2: Writing bit 0 at offset 0x08 requests a role: 0 is read prefetch, 1 is program staging. The readback still shows the old role on the cycle after the write. It shows the new role once SWITCH_LAT (4) idle cycles have passed. The role never changes while a transfer is running.
- R3: In program mode, each write to the data port (offset 0x0C) stores the next 32-bit word. Bits 7:0 of a word are its first byte on the wire and bits 31:24 are its fourth.
- R4: A push is ignored when 32 words have already been stored since the last pointer reset, or when the block is in read mode. Stored contents survive role changes and program commands.
- R5: Writing 0x10 to the command register (offset 0x00) sends one frame under a single chip-select low window. The frame is opcode 0x02, then the address bytes, then the 128 stored bytes in fill order, all in SPI mode 0 with MSB first.
- R6: When bit 4 of the mode register (offset 0x04) is 1, all four address bytes are sent (byte 3 first). When it is 0, only address bytes 2, 1 and 0 are sent.
- R7: Address bytes 0, 1 and 2 are written at offsets 0x10, 0x14 and 0x18. Address byte 3 is written at offset 0x20.
- R8: Command register bit 4 reads 1 from the cycle after a program command until the frame ends, and reads 0 afterwards.
- R9: No frame starts when a command is written in read mode, or when the command code is not 0x10.
- R10: The word pointer returns to word 0 after each program frame and when program mode is entered. It does not clear the stored words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |

## Verification
The assertions check on every cycle that chip select stays low for the whole transfer and that the clock stays low while the flash is deselected. They also check that the word pointer never passes 32 and holds there against extra pushes, that it returns to zero after a frame, that a frame starts only in program mode, and that the role holds steady during a transfer. Only the bench scenarios can show the byte order on the wire and the choice of three or four address bytes. The same goes for the delayed role readback, and for pushes made in read mode leaving the stored page intact through a later program frame.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam logic [7:0] PP_OPCODE   = 8'h02;
  localparam logic [7:0] CMD_PROGRAM = 8'h10;

  localparam logic [7:0] OFF_CMD   = 8'h00;
  localparam logic [7:0] OFF_MODE  = 8'h04;
  localparam logic [7:0] OFF_CFG   = 8'h08;
  localparam logic [7:0] OFF_DATA  = 8'h0C;
  localparam logic [7:0] OFF_ADDR0 = 8'h10;
  localparam logic [7:0] OFF_ADDR1 = 8'h14;
  localparam logic [7:0] OFF_ADDR2 = 8'h18;
  localparam logic [7:0] OFF_ADDR3 = 8'h20;

  // k-th address byte on the wire, most significant first
  function automatic logic [7:0] addr_byte(input logic [31:0] a,
                                           input logic four,
                                           input logic [2:0] k);
    logic [2:0] pos;
    pos = four ? (3'd3 - k) : (3'd2 - k);
    return 8'(a >> {pos, 3'b000});
  endfunction

  // little-endian byte lane of a stored word
  function automatic logic [7:0] word_byte(input logic [31:0] w,
                                           input logic [1:0] lane);
    return 8'(w >> {lane, 3'b000});
  endfunction
endpackage

// File: rtl/pp_regs.sv
module pp_regs
  import pp_pkg::*;
#(
  parameter int SWITCH_LAT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  input  logic        busy,
  output logic [31:0] bus_rdata,
  output logic        mode_eff,
  output logic        enter_prog,
  output logic        start_req,
  output logic        push_req,
  output logic        wide_addr,
  output logic [31:0] addr_word
);
  localparam int CW = $clog2(SWITCH_LAT + 1);
  localparam logic [CW-1:0] SW_LAST = CW'(SWITCH_LAT - 1);

  logic          mode_req;
  logic [CW-1:0] sw_cnt;
  logic          switching;
  logic          sw_fire;

  assign switching  = (mode_req != mode_eff) && !busy;
  assign sw_fire    = switching && (sw_cnt == SW_LAST);
  assign enter_prog = sw_fire && mode_req;
  assign push_req   = bus_wr && (bus_addr == OFF_DATA);
  assign start_req  = bus_wr && (bus_addr == OFF_CMD) &&
                      (bus_wdata[7:0] == CMD_PROGRAM) &&
                      mode_eff && (mode_req == mode_eff) && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_req  <= 1'b0;
      mode_eff  <= 1'b0;
      sw_cnt    <= '0;
      wide_addr <= 1'b0;
      addr_word <= '0;
    end else begin
      if (switching) begin
        if (sw_fire) begin
          mode_eff <= mode_req;
          sw_cnt   <= '0;
        end else begin
          sw_cnt <= sw_cnt + 1'b1;
        end
      end else begin
        sw_cnt <= '0;
      end
      if (bus_wr) begin
        unique case (bus_addr)
          OFF_CFG:   mode_req         <= bus_wdata[0];
          OFF_MODE:  wide_addr        <= bus_wdata[4];
          OFF_ADDR0: addr_word[7:0]   <= bus_wdata[7:0];
          OFF_ADDR1: addr_word[15:8]  <= bus_wdata[7:0];
          OFF_ADDR2: addr_word[23:16] <= bus_wdata[7:0];
          OFF_ADDR3: addr_word[31:24] <= bus_wdata[7:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFF_CMD:   bus_rdata[4] = busy;
      OFF_MODE:  bus_rdata[4] = wide_addr;
      OFF_CFG:   bus_rdata[0] = mode_eff;
      OFF_ADDR0: bus_rdata[7:0] = addr_word[7:0];
      OFF_ADDR1: bus_rdata[7:0] = addr_word[15:8];
      OFF_ADDR2: bus_rdata[7:0] = addr_word[23:16];
      OFF_ADDR3: bus_rdata[7:0] = addr_word[31:24];
      default: ;
    endcase
  end
endmodule

// File: rtl/pp_store.sv
module pp_store #(
  parameter int WORDS = 32,
  localparam int IW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          mode_eff,
  input  logic          busy,
  input  logic          enter_prog,
  input  logic          done,
  input  logic [31:0]   wdata,
  input  logic [IW-1:0] rd_idx,
  output logic [31:0]   rd_word,
  output logic          push_ok,
  output logic [IW:0]   ptr
);
  logic [31:0] mem_q [WORDS];

  assign push_ok = push_req && mode_eff && !busy && (ptr < (IW+1)'(WORDS));
  assign rd_word = mem_q[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (enter_prog || done) begin
      ptr <= '0;
    end else if (push_ok) begin
      ptr <= ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem_q[ptr[IW-1:0]] <= wdata;
  end
endmodule

// File: rtl/pp_shifter.sv
module pp_shifter #(
  parameter int PAGE_BYTES = 128,
  parameter int SCK_HALF   = 1,
  localparam int IDXW = $clog2(PAGE_BYTES + 5),
  localparam int DW   = $clog2(SCK_HALF + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            wide_in,
  input  logic [31:0]     addr_in,
  input  logic [7:0]      byte_val,
  output logic [IDXW-1:0] byte_idx,
  output logic            wide_l,
  output logic [31:0]     addr_l,
  output logic            busy,
  output logic            done,
  output logic            spi_sck,
  output logic            spi_cs_n,
  output logic            spi_mosi
);
  localparam logic [DW-1:0] DIV_LAST = DW'(SCK_HALF - 1);

  logic [DW-1:0]   div_q;
  logic [2:0]      bit_q;
  logic [IDXW-1:0] last_idx;

  assign last_idx = IDXW'(PAGE_BYTES) + (wide_l ? IDXW'(4) : IDXW'(3));
  assign spi_mosi = !spi_cs_n && byte_val[bit_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      spi_sck  <= 1'b0;
      spi_cs_n <= 1'b1;
      div_q    <= '0;
      bit_q    <= 3'd7;
      byte_idx <= '0;
      wide_l   <= 1'b0;
      addr_l   <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy     <= 1'b1;
          spi_cs_n <= 1'b0;
          spi_sck  <= 1'b0;
          div_q    <= '0;
          bit_q    <= 3'd7;
          byte_idx <= '0;
          wide_l   <= wide_in;
          addr_l   <= addr_in;
        end
      end else if (div_q == DIV_LAST) begin
        div_q <= '0;
        if (!spi_sck) begin
          spi_sck <= 1'b1;
        end else begin
          spi_sck <= 1'b0;
          if (bit_q == 3'd0) begin
            bit_q <= 3'd7;
            if (byte_idx == last_idx) begin
              busy     <= 1'b0;
              spi_cs_n <= 1'b1;
              done     <= 1'b1;
              byte_idx <= '0;
            end else begin
              byte_idx <= byte_idx + 1'b1;
            end
          end else begin
            bit_q <= bit_q - 1'b1;
          end
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pp_stage_buf.sv
module pp_stage_buf
  import pp_pkg::*;
#(
  parameter int WORDS      = 32,
  parameter int SWITCH_LAT = 4,
  parameter int SCK_HALF   = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        spi_sck,
  output logic        spi_cs_n,
  output logic        spi_mosi
);
  localparam int PAGE_BYTES = WORDS * 4;
  localparam int IW   = $clog2(WORDS);
  localparam int IDXW = $clog2(PAGE_BYTES + 5);

  logic            mode_eff, enter_prog, start_req, push_req, push_ok;
  logic            wide_addr, wide_l, busy, done;
  logic [31:0]     addr_word, addr_l, rd_word;
  logic [IW:0]     ptr;
  logic [IW-1:0]   rd_idx;
  logic [IDXW-1:0] byte_idx, alen, pidx;
  logic [7:0]      byte_val;

  pp_regs #(.SWITCH_LAT(SWITCH_LAT)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .busy(busy), .bus_rdata(bus_rdata),
    .mode_eff(mode_eff), .enter_prog(enter_prog), .start_req(start_req),
    .push_req(push_req), .wide_addr(wide_addr), .addr_word(addr_word)
  );

  pp_store #(.WORDS(WORDS)) store_i (
    .clk(clk), .rst_n(rst_n), .push_req(push_req), .mode_eff(mode_eff),
    .busy(busy), .enter_prog(enter_prog), .done(done), .wdata(bus_wdata),
    .rd_idx(rd_idx), .rd_word(rd_word), .push_ok(push_ok), .ptr(ptr)
  );

  pp_shifter #(.PAGE_BYTES(PAGE_BYTES), .SCK_HALF(SCK_HALF)) shift_i (
    .clk(clk), .rst_n(rst_n), .start(start_req), .wide_in(wide_addr),
    .addr_in(addr_word), .byte_val(byte_val), .byte_idx(byte_idx),
    .wide_l(wide_l), .addr_l(addr_l), .busy(busy), .done(done),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi)
  );

  // frame layout: opcode, address bytes, page bytes
  assign alen   = wide_l ? IDXW'(4) : IDXW'(3);
  assign pidx   = byte_idx - alen - IDXW'(1);
  assign rd_idx = IW'(pidx >> 2);

  always_comb begin
    if (byte_idx == '0)
      byte_val = PP_OPCODE;
    else if (byte_idx <= alen)
      byte_val = addr_byte(addr_l, wide_l, 3'(byte_idx - IDXW'(1)));
    else
      byte_val = word_byte(rd_word, pidx[1:0]);
  end
endmodule

// File: rtl/pp_stage_buf_chk.sv
module pp_stage_buf_chk #(
  parameter int WORDS = 32,
  localparam int IW = $clog2(WORDS)
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        spi_cs_n,
  input logic        spi_sck,
  input logic        mode_eff,
  input logic        push_req,
  input logic        enter_prog,
  input logic [IW:0] ptr
);
  localparam logic [IW:0] FULL = (IW+1)'(WORDS);

  p_cs_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !spi_cs_n);

  p_sck_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= FULL);

  p_full_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && ptr == FULL && !done && !enter_prog) |=> ptr == FULL);

  p_ptr_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ptr == '0);

  p_start_prog_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(mode_eff));

  p_mode_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mode_eff));
endmodule

bind pp_stage_buf pp_stage_buf_chk #(.WORDS(WORDS)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .mode_eff(mode_eff),
  .push_req(push_req), .enter_prog(enter_prog), .ptr(ptr)
);

// File: tb/pp_stage_buf_tb_top.sv
`timescale 1ns/1ps
module pp_stage_buf_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        spi_sck, spi_cs_n, spi_mosi;

  int n_cmp = 0;
  int n_bad = 0;
  int frames = 0;

  always #2.5 clk = ~clk;

  pp_stage_buf dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi)
  );

  // requirement model
  logic [31:0] model [32];
  bit          mprog = 0;
  int          mptr  = 0;
  logic [7:0]  exp_q [$];
  int          len_q [$];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic push(logic [31:0] w);
    wr(8'h0C, w);
    if (mprog && mptr < 32) begin
      model[mptr] = w;
      mptr++;
    end
  endtask

  task automatic set_role(bit p);
    wr(8'h08, {31'b0, p});
    repeat (10) @(negedge clk);
    if (p && !mprog) mptr = 0;
    mprog = p;
  endtask

  // driver: queue the frame the requirements predict, then issue the command
  task automatic program_page(logic [31:0] addr, bit four);
    int alen = four ? 4 : 3;
    exp_q.push_back(8'h02);
    for (int k = alen - 1; k >= 0; k--) exp_q.push_back(8'(addr >> (8 * k)));
    for (int b = 0; b < 128; b++) exp_q.push_back(8'(model[b / 4] >> (8 * (b % 4))));
    len_q.push_back(1 + alen + 128);
    wr(8'h00, 32'h10);
    mptr = 0;
  endtask

  task automatic wait_idle(string req);
    logic [31:0] d;
    int n = 0;
    do begin
      rd(8'h00, d);
      n++;
    end while (d[4] && n < 6000);
    chk(req, d, 32'h0);
  endtask

  // monitor: rebuild bytes from the wire and compare against the scoreboard
  logic [7:0] sh;
  int nbits = 0, nbytes = 0;
  bit in_frame = 0;

  always @(negedge spi_cs_n) begin
    in_frame = 1; nbits = 0; nbytes = 0;
  end

  always @(posedge spi_sck) begin
    if (!spi_cs_n) begin
      sh = {sh[6:0], spi_mosi};
      nbits++;
      if (nbits == 8) begin
        nbits = 0;
        nbytes++;
        if (exp_q.size() == 0) chk("R5 unexpected byte", {24'b0, sh}, 32'hFFFF_FFFF);
        else chk("R3/R5/R6 wire byte", {24'b0, sh}, {24'b0, exp_q.pop_front()});
      end
    end
  end

  always @(posedge spi_cs_n) begin
    if (in_frame) begin
      in_frame = 0;
      frames++;
      if (len_q.size() == 0) chk("R9 unexpected frame", 32'(nbytes), 32'h0);
      else chk("R5 frame length", 32'(nbytes), 32'(len_q.pop_front()));
    end
  end

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int f0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    #1;
    chk("R1 cs_n", {31'b0, spi_cs_n}, 32'h1);
    chk("R1 sck", {31'b0, spi_sck}, 32'h0);
    chk("R1 mosi", {31'b0, spi_mosi}, 32'h0);
    rd(8'h08, d); chk("R1 role", d, 32'h0);
    rd(8'h00, d); chk("R1 busy", d, 32'h0);

    // R9 command in read mode
    wr(8'h00, 32'h10);
    repeat (60) @(negedge clk);
    chk("R9 read-mode cmd", 32'(frames), 32'h0);

    // R2 delayed role readback
    wr(8'h08, 32'h1);
    rd(8'h08, d); chk("R2 old role", d, 32'h0);
    repeat (8) @(negedge clk);
    rd(8'h08, d); chk("R2 new role", d, 32'h1);
    mprog = 1; mptr = 0;

    // R7 address registers, R6 three-byte mode
    wr(8'h10, 32'h78); wr(8'h14, 32'h56); wr(8'h18, 32'h34); wr(8'h20, 32'h12);
    wr(8'h04, 32'h0);
    rd(8'h20, d); chk("R7 addr byte3", d, 32'h12);
    rd(8'h18, d); chk("R7 addr byte2", d, 32'h34);
    for (int i = 0; i < 32; i++) push(32'h03020100 + i * 32'h04040404);
    push(32'hFFEEDDCC); // R4 33rd push ignored
    program_page(32'h12345678, 0);
    rd(8'h00, d); chk("R8 busy set", d, 32'h10);
    wait_idle("R8 busy clear");
    chk("R5 one frame", 32'(frames), 32'h1);

    // R10 pointer back at word 0, R6 four-byte address
    wr(8'h04, 32'h10);
    wr(8'h20, 32'h9A);
    for (int i = 0; i < 32; i++) push(32'h83828180 + i * 32'h04040404);
    program_page(32'h9A345678, 1);
    wait_idle("R8 busy clear 2");

    // R9 wrong command code
    f0 = frames;
    wr(8'h00, 32'h11);
    repeat (60) @(negedge clk);
    chk("R9 bad code", 32'(frames), 32'(f0));

    // R4 push in read mode ignored, contents kept
    set_role(0);
    push(32'hDEADBEEF);
    set_role(1);
    program_page(32'h9A345678, 1);
    wait_idle("R4 keep contents");

    // R10 pointer reset on entering program mode
    push(32'h11111111); push(32'h22222222); push(32'h33333333);
    set_role(0);
    set_role(1);
    push(32'h44444444);
    program_page(32'h9A345678, 1);
    wait_idle("R10 enter reset");
    chk("R10 model word0", model[0], 32'h44444444);
    chk("R5 queue drained", 32'(exp_q.size()), 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule